// File: doc/BRIEF.md
# Write-Only Serial Control Register Slave

This block is the configuration port of a clock generator. It sits on an I2C bus as a slave that only accepts writes, and it loads a small bank of eight-bit control registers. The registers drive the output-enable and frequency-select logic. SCL and SDA are oversampled by the system clock, which must run at least eight times faster than SCL. The block acknowledges a byte by pulling SDA low through an open-drain enable output.

A write transfer carries, in order: the device address byte, two framing bytes whose contents do not matter, and then the data bytes. The transfer has no subaddress. The first data byte always lands in register 0, the next in register 1, and so on. To change a later register, a host must therefore resend every register in front of it.

An active-low power-down input freezes the bus logic while it is low, and the registers keep their contents. The registers return to their built-in defaults only on the power-on reset.

Top module: `clkgen_ctl_slave`

## Requirements
- R1: After power-on reset, each register i appears on `regs_o[8*i+7:8*i]` with these values: reg0 0x0C, reg1 0xCF, reg2 0x7F, reg3 0xFF, reg4 0x00, reg5 0x33, reg6 0x00, reg7 0x07. `sda_pull` is 0.
- R2: Only the address byte 0xD2 (7-bit address 0x69 with the write bit 0) is acknowledged. Any other first byte, including the read form 0xD3, gets no acknowledge. Nothing is written until the next START.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bytes clocked without a preceding START are ignored.
- R4: Bytes are received MSB first. For each accepted byte, `sda_pull` is 1 during the ninth SCL pulse and is raised only while SCL is low.
- R5: The two bytes after the address are acknowledged and discarded. The data bytes that follow fill register 0, 1, 2, … in ascending order.
- R6: Every transfer starts again at register 0. Registers beyond the last data byte sent keep their values.
- R7: Up to 10 data bytes are acknowledged per transfer. Data bytes 9 and 10 have no register and change nothing. The 11th data byte and any after it get no acknowledge.
- R8: While `pd_n` is 0, `sda_pull` stays 0, bus activity is ignored, and the registers keep their values. Once `pd_n` is 1 again, a new transfer works normally.
- R9: A repeated START at any point drops the partial byte and returns to the address phase.
- R10: A register changes only after all 8 bits of its data byte have arrived. A transfer cut off inside a byte leaves that register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low power-on reset; loads the register defaults |
| pd_n | input | 1 | Active-low power-down; freezes the bus logic, keeps the registers |
| scl_i | input | 1 | I2C serial clock as seen on the bus |
| sda_i | input | 1 | I2C serial data as seen on the bus |
| sda_pull | output | 1 | 1 drives SDA low (open-drain acknowledge) |
| regs_o | output | 64 | Register bank; register i sits in bits 8*i+7:8*i |

## Verification
The bench sweeps all 255 wrong address bytes. A design with a loose address compare would acknowledge one of them. It also sweeps transfers of one to eight data bytes, so a design that keeps its register pointer between transfers, or that fails to skip the two framing bytes, writes the wrong registers. An eleven-byte transfer checks the acknowledge limit. Separate cases cut a byte short with a repeated START and with a STOP. A design that commits partial bytes, or that does not restart at the address phase, fails these. The power-down case checks that the block neither acknowledges nor writes while frozen.

// File: rtl/clkgen_ctl_slave.sv
module clkgen_ctl_slave #(
  parameter logic [6:0]     DEV_ADDR    = 7'h69,
  parameter int             NREG        = 8,
  parameter int             FRAME_BYTES = 2,
  parameter int             MAX_DATA    = 10,
  parameter logic [NREG*8-1:0] REG_INIT = 64'h0700_3300_FF7F_CF0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull,
  output logic [NREG*8-1:0] regs_o
);

  localparam int FIRST_DATA = 1 + FRAME_BYTES;
  localparam int BCW        = $clog2(FIRST_DATA + MAX_DATA + 1);

  typedef enum logic [1:0] {S_IDLE, S_BITS, S_ACK} phase_t;

  logic [1:0]     scl_sync, sda_sync;
  logic           scl_q, sda_q;
  phase_t         st;
  logic [3:0]     bitcnt;
  logic [BCW-1:0] bcnt;
  logic [6:0]     shreg;
  logic           take;
  logic           accept;

  wire scl_s = scl_sync[1];
  wire sda_s = sda_sync[1];

  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire bus_start = scl_s & scl_q & sda_q & ~sda_s;
  wire bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

  wire [7:0] byte_nxt  = {shreg, sda_s};
  wire       byte_done = (st == S_BITS) && scl_rise && (bitcnt == 4'd7);
  wire       wr_en     = pd_n && byte_done && accept && (int'(bcnt) >= FIRST_DATA)
                         && (int'(bcnt) < FIRST_DATA + NREG);

  always_comb begin
    if (bcnt == '0)                           accept = (byte_nxt == {DEV_ADDR, 1'b0});
    else if (int'(bcnt) < FIRST_DATA)         accept = 1'b1;
    else                                      accept = int'(bcnt) < FIRST_DATA + MAX_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      bcnt     <= '0;
      shreg    <= '0;
      take     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (!pd_n) begin
      st       <= S_IDLE;
      sda_pull <= 1'b0;
    end else if (bus_start) begin
      st       <= S_BITS;
      bitcnt   <= '0;
      bcnt     <= '0;
      sda_pull <= 1'b0;
    end else if (bus_stop) begin
      st       <= S_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (st)
        S_BITS: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= byte_nxt[6:0];
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) take <= accept;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (take) begin
              st       <= S_ACK;
              sda_pull <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            st       <= S_BITS;
            bitcnt   <= '0;
            bcnt     <= bcnt + BCW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_o <= REG_INIT;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (int'(bcnt) == FIRST_DATA + i) regs_o[8*i +: 8] <= byte_nxt;
    end
  end

  a_r8_release_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> !sda_pull);

  a_r8_hold_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> $stable(regs_o));

  a_r4_ack_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);

  a_r7_ack_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK) |-> (int'(bcnt) < FIRST_DATA + MAX_DATA));

  a_r10_full_byte_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> (bitcnt == 4'd8));

endmodule

// File: tb/clkgen_ctl_slave_test.sv
module clkgen_ctl_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int NREG       = 8;
  localparam int MAXD       = 10;

  logic clk = 1'b0, rst_n = 1'b0, pd_n = 1'b1, m_scl = 1'b1, m_sda = 1'b1;
  logic              sda_pull;
  logic [NREG*8-1:0] regs;
  wire sda_bus = m_sda & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgen_ctl_slave uut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_pull(sda_pull), .regs_o(regs)
  );

  int checks = 0, fails = 0;
  logic [7:0] exp_reg [NREG];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic check_regs(input string req);
    logic [NREG*8-1:0] e;
    for (int i = 0; i < NREG; i++) e[8*i +: 8] = exp_reg[i];
    check(regs === e, req, "register bank", regs, e);
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 91 + 13) ^ (i << 5));
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int k = 7; k > 7 - n; k--) begin
      m_sda = b[k]; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    ack = (sda_bus === 1'b0);
    tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic do_write(input int n, input int seed, input bit live, input string req);
    bit ack;
    bus_start();
    send_byte(8'hD2, ack);
    check(ack == live, req, "address ack", ack, live);
    for (int f = 0; f < 2; f++) begin
      send_byte(8'(seed ^ (f * 8'h5B)), ack);
      check(ack == live, "R5", "framing byte ack", ack, live);
    end
    for (int i = 0; i < n; i++) begin
      bit want = live && (i < MAXD);
      send_byte(pat(seed, i), ack);
      check(ack == want, (i < MAXD) ? "R4" : "R7", "data byte ack", ack, want);
      if (want && i < NREG) exp_reg[i] = pat(seed, i);
    end
    bus_stop();
    tick(4);
  endtask

  initial begin
    bit ack;
    exp_reg = '{8'h0C, 8'hCF, 8'h7F, 8'hFF, 8'h00, 8'h33, 8'h00, 8'h07};
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check_regs("R1");
    check(sda_pull === 1'b0, "R1", "pull after reset", sda_pull, 0);

    do_write(8, 3, 1'b1, "R2");
    check_regs("R5");

    for (int n = 1; n <= NREG; n++) begin
      do_write(n, 100 + n, 1'b1, "R2");
      check_regs("R6");
    end

    do_write(MAXD + 1, 55, 1'b1, "R2");
    check_regs("R7");

    for (int a = 0; a < 256; a++) begin
      if (a == 8'hD2) continue;
      bus_start();
      send_byte(8'(a), ack);
      check(!ack, "R2", "foreign address acked", ack, 0);
      bus_stop();
    end
    check_regs("R2");

    bus_start();
    send_byte(8'hD3, ack);
    check(!ack, "R2", "read request acked", ack, 0);
    for (int i = 0; i < 4; i++) send_byte(8'h99, ack);
    bus_stop();
    tick(4);
    check_regs("R2");

    send_byte(8'hD2, ack);
    check(!ack, "R3", "byte without START acked", ack, 0);
    bus_stop();
    tick(4);

    pd_n = 1'b0; tick(4);
    do_write(5, 77, 1'b0, "R8");
    check_regs("R8");
    pd_n = 1'b1; tick(4);
    do_write(2, 78, 1'b1, "R8");
    check_regs("R8");

    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    send_bits(8'h5A, 4);
    bus_start();
    send_byte(8'hD2, ack);
    check(ack, "R9", "address after repeated START", ack, 1);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    send_byte(8'h3C, ack);
    check(ack, "R9", "data after repeated START", ack, 1);
    exp_reg[0] = 8'h3C;
    bus_stop();
    tick(4);
    check_regs("R9");

    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    send_byte(8'h81, ack);
    exp_reg[0] = 8'h81;
    send_bits(8'h7E, 5);
    bus_stop();
    tick(4);
    check_regs("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule